// File: doc/BRIEF.md
# Streaming Binary Opening Filter

This block cleans a binary mask taken from a live raster video stream. Each 8-bit grayscale pixel is compared against a fixed level to give one foreground bit. The resulting bit stream then passes through a morphological opening. A chain of 3x3 erosion stages first removes thin lines, isolated specks and narrow bridges. A chain of 3x3 dilation stages then grows the surviving regions back toward their original size. Horizontal sync, vertical sync and data-enable travel down the same pipeline, so the cleaned bit leaves the block with qualifiers that still describe it.

Each 3x3 stage builds its window from two line-length delay lines and a small register window. Counters follow the position of the pixel entering the stage and mark the pixels that lie on the one-pixel frame edge. This mark moves through the stage with the qualifiers and blanks the edge pixels at the output. The image size, the line period in clocks, the threshold and the number of stages of each kind are parameters.

The block expects the following input timing. Every line lasts exactly `LINE_TOTAL` clocks. The active pixels of a line form one contiguous burst of `IMG_WIDTH` clocks, and vertical sync is asserted during vertical blanking, between frames.

Top module: `morph_open_top`

## Requirements
- R1: With in_de high, a gray value strictly above THRESH (default 92) becomes foreground (bit 1). A value equal to or below THRESH becomes background (bit 0).
- R2: An erosion stage outputs 1 for an interior pixel only when all nine pixels of the 3x3 neighbourhood centred on it are 1.
- R3: A dilation stage outputs 1 for an interior pixel when any of the nine pixels of the 3x3 neighbourhood centred on it is 1.
- R4: N_ERODE (default 3) erosion stages come first and N_DILATE (default 3) dilation stages follow. Each stage consumes the output of the stage before it, so the result is an opening and never a closing.
- R5: Every stage forces to 0 the output pixels in row 0, row IMG_HEIGHT-1, column 0 and column IMG_WIDTH-1.
- R6: out_hs, out_vs and out_de equal in_hs, in_vs and in_de delayed by 1 + (N_ERODE+N_DILATE)*(LINE_TOTAL+2) clocks. Each 3x3 stage adds LINE_TOTAL+2 clocks. out_bin is 0 whenever out_de is 0.
- R7: The column of a pixel is the number of earlier in_de-high clocks in its line. The row is the number of active lines completed since the last clock with in_vs high. Frames sent back to back are each filtered independently of the frame before.
- R8: While rst_n is low at a rising clk edge, all outputs are cleared. After release, out_de and out_bin stay 0 until the first valid pixel has crossed the whole pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_hs | input | 1 | Horizontal sync in, active high |
| in_vs | input | 1 | Vertical sync in, active high |
| in_de | input | 1 | Input pixel valid |
| in_gray | input | PIX_W | Grayscale pixel value |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| out_de | output | 1 | Output pixel valid |
| out_bin | output | 1 | Opened binary pixel, 1 = foreground |

## Verification
The bench models the opening stage by stage on whole frames and compares all four outputs on every clock, so a one-clock skew between out_de and out_bin shows up at once.

It targets the following corner cases:
- A frame made of values 92 and 93 catches a threshold that compares with >= or one that is off by one, because the whole image would then turn into foreground.
- A solid block carrying a one-pixel hole tells opening from closing. Swapping the stage order would fill the hole instead of eroding the block away.
- A thin line and a lone speck next to a 7x7 block must vanish while the block returns at its exact size. A wrong neighbour tap or a missing window register would clip or shift the block.
- An all-bright frame exposes a border rule that is missing or off by one row or column, since each stage then pushes the edge inward by one pixel.

// File: rtl/morph_pkg.sv
package morph_pkg;

  // Kind of 3x3 reduction a window stage performs
  typedef enum logic {
    OP_ERODE  = 1'b0,
    OP_DILATE = 1'b1
  } morph_op_e;

  // Qualifiers that travel with each pixel; edge_px marks the frame rim
  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
    logic edge_px;
  } qual_t;

  localparam int QUAL_W = $bits(qual_t);

  // Foreground decision: strictly above the level
  function automatic logic above_level(input int unsigned value, input int unsigned level);
    return value > level;
  endfunction

  // Nine-input reduction chosen by the stage kind
  function automatic logic window_reduce(input morph_op_e op, input logic [8:0] win);
    return (op == OP_ERODE) ? (&win) : (|win);
  endfunction

  // True when (row, col) sits on the one-pixel rim of an h x w image
  function automatic logic on_border(input int row, input int col, input int h, input int w);
    return (row == 0) || (row == h - 1) || (col == 0) || (col == w - 1);
  endfunction

endpackage

// File: rtl/morph_delay.sv
module morph_delay #(
  parameter int WIDTH = 1,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             clear,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [DEPTH-1:0][WIDTH-1:0] taps;

  // Plain shift chain; q is d delayed by DEPTH clocks
  always_ff @(posedge clk) begin
    if (clear) begin
      taps <= '0;
    end else begin
      taps[0] <= d;
      for (int i = 1; i < DEPTH; i++) begin
        taps[i] <= taps[i-1];
      end
    end
  end

  assign q = taps[DEPTH-1];

endmodule

// File: rtl/morph_threshold.sv
module morph_threshold
  import morph_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int THRESH = 92
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_hs,
  input  logic             in_vs,
  input  logic             in_de,
  input  logic [PIX_W-1:0] in_gray,
  output logic             out_hs,
  output logic             out_vs,
  output logic             out_de,
  output logic             out_bin
);

  logic fg_now;
  assign fg_now = in_de && above_level(int'(in_gray), THRESH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_hs  <= 1'b0;
      out_vs  <= 1'b0;
      out_de  <= 1'b0;
      out_bin <= 1'b0;
    end else begin
      out_hs  <= in_hs;
      out_vs  <= in_vs;
      out_de  <= in_de;
      out_bin <= fg_now;
    end
  end

endmodule

// File: rtl/morph_stage.sv
module morph_stage
  import morph_pkg::*;
#(
  parameter int        IMG_WIDTH  = 16,
  parameter int        IMG_HEIGHT = 12,
  parameter int        LINE_TOTAL = 24,
  parameter morph_op_e OP         = OP_ERODE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_hs,
  input  logic in_vs,
  input  logic in_de,
  input  logic in_bin,
  output logic out_hs,
  output logic out_vs,
  output logic out_de,
  output logic out_bin,
  output logic ctr_bin,
  output logic ctr_inner
);

  localparam int CW = $clog2(IMG_WIDTH + 1);
  localparam int RW = $clog2(IMG_HEIGHT + 1);

  // Position of the pixel entering this stage
  logic [CW-1:0] col_q;
  logic [RW-1:0] row_q;
  logic          de_prev;
  logic          line_done;

  assign line_done = de_prev && !in_de;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q   <= '0;
      row_q   <= '0;
      de_prev <= 1'b0;
    end else begin
      de_prev <= in_de;
      col_q   <= in_de ? col_q + 1'b1 : '0;
      if (in_vs) begin
        row_q <= '0;
      end else if (line_done) begin
        row_q <= row_q + 1'b1;
      end
    end
  end

  logic px_edge;
  assign px_edge = in_de && on_border(int'(row_q), int'(col_q), IMG_HEIGHT, IMG_WIDTH);

  // Qualifiers delayed to the window centre (one line plus one clock)
  qual_t q_in, q_ctr;
  assign q_in = {in_hs, in_vs, in_de, px_edge};

  morph_delay #(.WIDTH(QUAL_W), .DEPTH(LINE_TOTAL + 1)) u_qual_dly (
    .clk   (clk),
    .clear (!rst_n),
    .d     (q_in),
    .q     (q_ctr)
  );

  // Two line delays give the rows above the newest pixel
  logic x_now, x_up1, x_up2;
  assign x_now = in_de & in_bin;

  morph_delay #(.WIDTH(1), .DEPTH(LINE_TOTAL)) u_line_a (
    .clk   (clk),
    .clear (1'b0),
    .d     (x_now),
    .q     (x_up1)
  );

  morph_delay #(.WIDTH(1), .DEPTH(LINE_TOTAL)) u_line_b (
    .clk   (clk),
    .clear (1'b0),
    .d     (x_up1),
    .q     (x_up2)
  );

  // Window columns, each {top, middle, bottom}
  logic [2:0] col_new, col_mid, col_old;
  assign col_new = {x_up2, x_up1, x_now};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_mid <= '0;
      col_old <= '0;
    end else begin
      col_mid <= col_new;
      col_old <= col_mid;
    end
  end

  logic [8:0] win;
  logic       win_hit;
  assign win     = {col_new, col_mid, col_old};
  assign win_hit = window_reduce(OP, win);

  // Named events for the checker
  assign ctr_bin   = col_mid[1];
  assign ctr_inner = q_ctr.de && !q_ctr.edge_px;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_hs  <= 1'b0;
      out_vs  <= 1'b0;
      out_de  <= 1'b0;
      out_bin <= 1'b0;
    end else begin
      out_hs  <= q_ctr.hs;
      out_vs  <= q_ctr.vs;
      out_de  <= q_ctr.de;
      out_bin <= ctr_inner && win_hit;
    end
  end

endmodule

// File: rtl/morph_open_top.sv
module morph_open_top
  import morph_pkg::*;
#(
  parameter int PIX_W      = 8,
  parameter int THRESH     = 92,
  parameter int IMG_WIDTH  = 16,
  parameter int IMG_HEIGHT = 12,
  parameter int LINE_TOTAL = 24,
  parameter int N_ERODE    = 3,
  parameter int N_DILATE   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_hs,
  input  logic             in_vs,
  input  logic             in_de,
  input  logic [PIX_W-1:0] in_gray,
  output logic             out_hs,
  output logic             out_vs,
  output logic             out_de,
  output logic             out_bin
);

  localparam int NSTG      = N_ERODE + N_DILATE;
  localparam int STAGE_LAT = LINE_TOTAL + 2;
  localparam int PIPE_LAT  = 1 + NSTG * STAGE_LAT;

  // Index 0 is the threshold output, index k+1 the output of window stage k
  logic [NSTG:0]   s_hs, s_vs, s_de, s_bin;
  logic [NSTG-1:0] s_ctr, s_inner;

  morph_threshold #(.PIX_W(PIX_W), .THRESH(THRESH)) u_thr (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_hs   (in_hs),
    .in_vs   (in_vs),
    .in_de   (in_de),
    .in_gray (in_gray),
    .out_hs  (s_hs[0]),
    .out_vs  (s_vs[0]),
    .out_de  (s_de[0]),
    .out_bin (s_bin[0])
  );

  for (genvar k = 0; k < NSTG; k++) begin : g_stage
    localparam morph_op_e K_OP = (k < N_ERODE) ? OP_ERODE : OP_DILATE;

    morph_stage #(
      .IMG_WIDTH  (IMG_WIDTH),
      .IMG_HEIGHT (IMG_HEIGHT),
      .LINE_TOTAL (LINE_TOTAL),
      .OP         (K_OP)
    ) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_hs     (s_hs[k]),
      .in_vs     (s_vs[k]),
      .in_de     (s_de[k]),
      .in_bin    (s_bin[k]),
      .out_hs    (s_hs[k+1]),
      .out_vs    (s_vs[k+1]),
      .out_de    (s_de[k+1]),
      .out_bin   (s_bin[k+1]),
      .ctr_bin   (s_ctr[k]),
      .ctr_inner (s_inner[k])
    );
  end

  assign out_hs  = s_hs[NSTG];
  assign out_vs  = s_vs[NSTG];
  assign out_de  = s_de[NSTG];
  assign out_bin = s_bin[NSTG];

endmodule

// File: rtl/morph_open_chk.sv
module morph_open_chk #(
  parameter int PIX_W    = 8,
  parameter int THRESH   = 92,
  parameter int N_ERODE  = 3,
  parameter int N_DILATE = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_de,
  input logic [PIX_W-1:0]              in_gray,
  input logic                          out_de,
  input logic                          out_bin,
  input logic [N_ERODE+N_DILATE:0]     s_de,
  input logic [N_ERODE+N_DILATE:0]     s_bin,
  input logic [N_ERODE+N_DILATE-1:0]   s_ctr,
  input logic [N_ERODE+N_DILATE-1:0]   s_inner
);

  localparam int NSTG = N_ERODE + N_DILATE;

  // R1
  thr_fg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_de && int'(in_gray) > THRESH) |=> s_bin[0]);

  // R1
  thr_bg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_de && int'(in_gray) > THRESH) |=> !s_bin[0]);

  // R6
  thr_de_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_de |=> s_de[0]);

  // R6
  thr_de_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_de |=> !s_de[0]);

  // R6
  blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_de |-> !out_bin);

  for (genvar k = 0; k < NSTG; k++) begin : g_stage_chk
    // R5
    rim_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !s_inner[k] |=> !s_bin[k+1]);

    if (k < N_ERODE) begin : g_erode
      // R2
      erode_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_ctr[k] |=> !s_bin[k+1]);
    end else begin : g_dilate
      // R3
      dilate_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_inner[k] && s_ctr[k]) |=> s_bin[k+1]);
    end
  end

endmodule

bind morph_open_top morph_open_chk #(
  .PIX_W    (PIX_W),
  .THRESH   (THRESH),
  .N_ERODE  (N_ERODE),
  .N_DILATE (N_DILATE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_de   (in_de),
  .in_gray (in_gray),
  .out_de  (out_de),
  .out_bin (out_bin),
  .s_de    (s_de),
  .s_bin   (s_bin),
  .s_ctr   (s_ctr),
  .s_inner (s_inner)
);

// File: tb/test_morph_open_top.sv
module test_morph_open_top;

  localparam int W   = 16;
  localparam int H   = 12;
  localparam int L   = 24;
  localparam int VB  = 3;
  localparam int LAT = 1 + 6 * (L + 2);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_hs = 1'b0, in_vs = 1'b0, in_de = 1'b0;
  logic [7:0] in_gray = '0;
  logic       out_hs, out_vs, out_de, out_bin;

  always #5 clk = ~clk;

  morph_open_top i_morph_open_top (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_hs   (in_hs),
    .in_vs   (in_vs),
    .in_de   (in_de),
    .in_gray (in_gray),
    .out_hs  (out_hs),
    .out_vs  (out_vs),
    .out_de  (out_de),
    .out_bin (out_bin)
  );

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic       hs;
    logic       vs;
    logic       de;
    logic       bin;
    logic [7:0] req;
  } exp_t;

  exp_t exp_q[$];

  int gray_img [H][W];
  int ref_img  [7][H][W];

  // Reference opening: threshold, then 3 AND passes, then 3 OR passes
  task automatic build_ref();
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++)
        ref_img[0][r][c] = (gray_img[r][c] > 92) ? 1 : 0;
    for (int s = 1; s <= 6; s++) begin
      for (int r = 0; r < H; r++) begin
        for (int c = 0; c < W; c++) begin
          int ones = 0;
          if (r == 0 || c == 0 || r == H - 1 || c == W - 1) begin
            ref_img[s][r][c] = 0;
          end else begin
            for (int dr = -1; dr <= 1; dr++)
              for (int dc = -1; dc <= 1; dc++)
                ones += ref_img[s-1][r+dr][c+dc];
            if (s <= 3) ref_img[s][r][c] = (ones == 9) ? 1 : 0;
            else        ref_img[s][r][c] = (ones > 0) ? 1 : 0;
          end
        end
      end
    end
  endtask

  task automatic step(input logic hs, input logic vs, input logic de,
                      input int gray, input logic eb, input int req);
    @(negedge clk);
    if (exp_q.size() == LAT) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if ({out_hs, out_vs, out_de} !== {e.hs, e.vs, e.de}) begin
        errors++;
        $display("FAIL R6 qualifiers actual %b%b%b expected %b%b%b",
                 out_hs, out_vs, out_de, e.hs, e.vs, e.de);
      end else if (out_bin !== e.bin) begin
        errors++;
        $display("FAIL R%0d pixel actual %b expected %b", e.req, out_bin, e.bin);
      end
    end
    in_hs   = hs;
    in_vs   = vs;
    in_de   = de;
    in_gray = gray[7:0];
    exp_q.push_back('{hs: hs, vs: vs, de: de, bin: eb, req: req[7:0]});
  endtask

  // One frame: H active lines, then VB blank lines with vsync in the second
  task automatic send_frame(input int req);
    build_ref();
    for (int ln = 0; ln < H + VB; ln++) begin
      for (int c = 0; c < L; c++) begin
        logic de, hs, vs;
        int   g, rq;
        logic eb;
        de = (ln < H) && (c < W);
        hs = (c >= W + 2) && (c < W + 5);
        vs = (ln == H + 1);
        g  = de ? gray_img[ln][c] : 0;
        eb = de ? (ref_img[6][ln][c] != 0) : 1'b0;
        rq = (de && (ln == 0 || ln == H - 1 || c == 0 || c == W - 1)) ? 5 : req;
        step(hs, vs, de, g, eb, rq);
      end
    end
  endtask

  task automatic fill(input int v);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++)
        gray_img[r][c] = v;
  endtask

  task automatic rect(input int r0, input int r1, input int c0, input int c1, input int v);
    for (int r = r0; r <= r1; r++)
      for (int c = c0; c <= c1; c++)
        gray_img[r][c] = v;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL R6 watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    int unsigned seed;
    // R8: outputs cleared while reset is held
    repeat (4) @(negedge clk);
    checks++;
    if ({out_hs, out_vs, out_de, out_bin} !== 4'b0000) begin
      errors++;
      $display("FAIL R8 reset outputs actual %b%b%b%b expected 0000",
               out_hs, out_vs, out_de, out_bin);
    end
    rst_n = 1'b1;
    // R8: pipeline empty after release, compared through the prefilled queue
    for (int i = 0; i < LAT; i++) exp_q.push_back('{hs: 1'b0, vs: 1'b0, de: 1'b0, bin: 1'b0, req: 8'd8});
    for (int i = 0; i < 2 * L; i++) step(1'b0, 1'b0, 1'b0, 0, 1'b0, 8);

    // R5: all bright, rim blanked stage after stage
    fill(200);
    send_frame(5);

    // R1: block at 93 on a 92 background; only the block is foreground
    fill(92);
    rect(2, 9, 2, 13, 93);
    send_frame(1);

    // R2: thin line and lone speck removed by erosion, block kept
    fill(10);
    rect(2, 8, 2, 8, 255);
    rect(5, 5, 9, 14, 255);
    gray_img[10][12] = 255;
    send_frame(2);

    // R3: dilation restores a 7x7 block exactly
    fill(0);
    rect(3, 9, 6, 12, 180);
    send_frame(3);

    // R4: block with a one-pixel hole; opening erases it, closing would not
    fill(0);
    rect(2, 8, 3, 9, 240);
    gray_img[5][6] = 40;
    send_frame(4);

    // R7: pseudo-random frame directly after the previous one
    seed = 32'h1234_5678;
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        gray_img[r][c] = (((seed >> 16) & 255) > 40) ? 200 : int'((seed >> 8) & 63);
      end
    end
    send_frame(7);

    // R6: flush with idle lines
    for (int i = 0; i < LAT + 8; i++) step(1'b0, 1'b0, 1'b0, 0, 1'b0, 6);
    finish_run();
  end

endmodule